// File: doc/BRIEF.md
# Banked Shared Memory Arbiter

This block is a scratchpad memory built from 32 single-access banks. Consecutive word addresses fall in consecutive banks and wrap around, so word 32 lands in bank 0 again. A 32-lane requester hands over one request vector at a time. Each lane carries an active bit, a word address, a write enable and write data. The block sorts the lanes by bank. In each cycle it serves every bank that has work, so lanes that use different banks finish together.

When several lanes read the same word, that word is fetched once and given to all of them, and this costs no extra cycle. When lanes use different words in the same bank, the block serves them over several rounds. In each round a bank serves the word asked for by its lowest-numbered waiting lane. While rounds remain, `stall` is high. Per-lane done bits and read data build up as the rounds complete, and they stay put until the next request is accepted.

Addresses count words of `WORD_W` bits. `WORD_W` may be 32 or 64, and the bank is always the word address modulo the bank count. The reset input is asynchronous and active low. Inside the block its release is synchronised to the clock, so the block leaves reset two clock edges after `rst_n` rises.

Top module: `banked_scratchpad`

## Requirements
- R1: While reset is applied, and afterwards until the first request, `stall` is 0 and every `lane_done` bit is 0.
- R2: Bits [4:0] of a lane's word address select the bank (address modulo 32) and bits [7:5] select the row in that bank. A later read of the same word address returns the data a write stored there.
- R3: A request is accepted on a rising edge where `req_valid` is 1 and `stall` is 0. If it has at least one active lane, `stall` is 1 from the next cycle. A request presented while `stall` is 1 is ignored: it performs no write and does not change the results of the request in progress.
- R4: When every active lane addresses a different bank, `stall` is high for exactly one cycle, and when it falls every active lane's done bit is set.
- R5: Any number of lanes reading the same word are served in one round, and all of them receive that word.
- R6: A bank holding k distinct requested words takes k rounds, so `stall` stays high for as many cycles as the largest such k over all banks. In each round a bank serves the word of its lowest-indexed waiting lane, together with every other waiting lane that asks for the same word.
- R7: When several lanes write the same word in the same round, the data of the highest-indexed of those lanes is stored.
- R8: A lane's done bit and read data appear in the cycle after the round that served it. They stay unchanged until the next request is accepted, and the done bit of an inactive lane is never set.
- R9: A lane that reads a word in the same round as a write to that word returns the value held before that write.
- R10: A request with no active lane is accepted without raising `stall`, and it clears all done bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request vector present |
| req_act | input | 32 | Per-lane active bit |
| req_addr | input | 32 x 8 | Per-lane word address |
| req_we | input | 32 | Per-lane write enable |
| req_wdata | input | 32 x WORD_W | Per-lane write data |
| stall | output | 1 | Request in progress; new requests are not accepted |
| lane_done | output | 32 | Per-lane served flag, held until the next accept |
| lane_rdata | output | 32 x WORD_W | Per-lane read data, held until the next accept |

## Verification
A wrong pending mask or a wrong bank choice shows up at the first falling edge after the round it corrupts. At that point the done vector differs from the cumulative mask that the round order predicts. For that reason, the done vector is compared on every cycle of a request, not only at its end. A wrong bank row, a wrong write winner or a wrong read-before-write choice leaves wrong data in the array. That shows in the read data of the same request or of the next read of that word, which is why the reference memory is kept across the whole run. A stuck or early `stall` shows up directly as a wrong count of busy cycles for that request.

// File: rtl/bsm_pkg.sv
package bsm_pkg;

  // Control phase of the request sequencer.
  typedef enum logic {
    PH_IDLE = 1'b0,
    PH_RUN  = 1'b1
  } phase_e;

  // Bits needed to name one word of the whole scratchpad.
  function automatic int word_addr_bits(int banks, int depth);
    return $clog2(banks) + $clog2(depth);
  endfunction

endpackage

// File: rtl/bsm_rst_sync.sv
// Reset conditioner: asserts asynchronously, releases on the second clock edge.
module bsm_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= 2'b00;
    end else begin
      sync_q <= {sync_q[0], 1'b1};
    end
  end

  assign rst_sync_n = sync_q[1];

endmodule

// File: rtl/bsm_bank_pick.sv
// Per-bank round selector: picks the word of the lowest waiting lane in this
// bank, serves every waiting lane on that word, highest writer supplies data.
module bsm_bank_pick #(
  parameter int LANES   = 32,
  parameter int BANK_W  = 5,
  parameter int ROW_W   = 3,
  parameter int WORD_W  = 32,
  parameter int BANK_ID = 0
) (
  input  logic [LANES-1:0]             pend,
  input  logic [LANES-1:0][BANK_W-1:0] lbank,
  input  logic [LANES-1:0][ROW_W-1:0]  lrow,
  input  logic [LANES-1:0]             lwe,
  input  logic [LANES-1:0][WORD_W-1:0] lwd,
  output logic [LANES-1:0]             serve,
  output logic                         wr,
  output logic [ROW_W-1:0]             row,
  output logic [WORD_W-1:0]            wd
);

  localparam logic [BANK_W-1:0] ID = BANK_W'(BANK_ID);

  logic [LANES-1:0] hit;
  logic             found;

  always_comb begin
    hit   = '0;
    row   = '0;
    found = 1'b0;
    for (int l = 0; l < LANES; l++) begin
      hit[l] = pend[l] && (lbank[l] == ID);
      if (hit[l] && !found) begin
        row   = lrow[l];
        found = 1'b1;
      end
    end
  end

  always_comb begin
    serve = '0;
    wr    = 1'b0;
    wd    = '0;
    for (int l = 0; l < LANES; l++) begin
      serve[l] = hit[l] && (lrow[l] == row);
      // Later (higher) lanes overwrite: highest-indexed writer wins.
      if (serve[l] && lwe[l]) begin
        wr = 1'b1;
        wd = lwd[l];
      end
    end
  end

endmodule

// File: rtl/bsm_bank_ram.sv
// One bank: a single row access per cycle, write at the edge, read through.
module bsm_bank_ram #(
  parameter int DEPTH  = 8,
  parameter int ROW_W  = 3,
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              wr,
  input  logic [ROW_W-1:0]  row,
  input  logic [WORD_W-1:0] wd,
  output logic [WORD_W-1:0] rd
);

  logic [WORD_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr) begin
      mem[row] <= wd;
    end
  end

  // Read sees the value before this cycle's write.
  assign rd = mem[row];

endmodule

// File: rtl/banked_scratchpad.sv
module banked_scratchpad
  import bsm_pkg::*;
#(
  parameter int LANES  = 32,
  parameter int BANKS  = 32,
  parameter int DEPTH  = 8,
  parameter int WORD_W = 32,
  // Derived; keep at its default.
  parameter int ADDR_W = word_addr_bits(BANKS, DEPTH)
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         req_valid,
  input  logic [LANES-1:0]             req_act,
  input  logic [LANES-1:0][ADDR_W-1:0] req_addr,
  input  logic [LANES-1:0]             req_we,
  input  logic [LANES-1:0][WORD_W-1:0] req_wdata,
  output logic                         stall,
  output logic [LANES-1:0]             lane_done,
  output logic [LANES-1:0][WORD_W-1:0] lane_rdata
);

  localparam int BANK_W = $clog2(BANKS);
  localparam int ROW_W  = $clog2(DEPTH);

  logic rst_i;

  bsm_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_i)
  );

  // Control state
  phase_e           ph_q, ph_d;
  logic [LANES-1:0] act_q, act_d;
  logic [LANES-1:0] pend_q, pend_d;
  logic [LANES-1:0] done_q, done_d;

  // Captured request and returned data
  logic [LANES-1:0][ADDR_W-1:0] addr_q;
  logic [LANES-1:0]             we_q;
  logic [LANES-1:0][WORD_W-1:0] wd_q;
  logic [LANES-1:0][WORD_W-1:0] rd_q;

  logic [LANES-1:0][BANK_W-1:0] lbank;
  logic [LANES-1:0][ROW_W-1:0]  lrow;

  logic [BANKS-1:0][LANES-1:0]  srv_b;
  logic [BANKS-1:0]             b_wr;
  logic [BANKS-1:0][ROW_W-1:0]  b_row;
  logic [BANKS-1:0][WORD_W-1:0] b_wd;
  logic [BANKS-1:0][WORD_W-1:0] b_rd;
  logic [LANES-1:0]             srv;
  logic                         accept;

  // Address split: low bits pick the bank, high bits the row.
  for (genvar l = 0; l < LANES; l++) begin : g_split
    assign lbank[l] = addr_q[l][BANK_W-1:0];
    assign lrow[l]  = addr_q[l][ADDR_W-1:BANK_W];
  end

  for (genvar b = 0; b < BANKS; b++) begin : g_bank
    bsm_bank_pick #(
      .LANES   (LANES),
      .BANK_W  (BANK_W),
      .ROW_W   (ROW_W),
      .WORD_W  (WORD_W),
      .BANK_ID (b)
    ) u_pick (
      .pend  (pend_q),
      .lbank (lbank),
      .lrow  (lrow),
      .lwe   (we_q),
      .lwd   (wd_q),
      .serve (srv_b[b]),
      .wr    (b_wr[b]),
      .row   (b_row[b]),
      .wd    (b_wd[b])
    );

    bsm_bank_ram #(
      .DEPTH  (DEPTH),
      .ROW_W  (ROW_W),
      .WORD_W (WORD_W)
    ) u_ram (
      .clk (clk),
      .wr  (b_wr[b]),
      .row (b_row[b]),
      .wd  (b_wd[b]),
      .rd  (b_rd[b])
    );
  end

  always_comb begin
    srv = '0;
    for (int b = 0; b < BANKS; b++) begin
      srv = srv | srv_b[b];
    end
  end

  assign accept = req_valid && (ph_q == PH_IDLE);

  // Next-state logic
  always_comb begin
    ph_d   = ph_q;
    act_d  = act_q;
    pend_d = pend_q;
    done_d = done_q;
    if (accept) begin
      act_d  = req_act;
      pend_d = req_act;
      done_d = '0;
      ph_d   = (|req_act) ? PH_RUN : PH_IDLE;
    end else if (ph_q == PH_RUN) begin
      pend_d = pend_q & ~srv;
      done_d = done_q | srv;
      if (pend_d == '0) begin
        ph_d = PH_IDLE;
      end
    end
  end

  // Control registers
  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      ph_q   <= PH_IDLE;
      act_q  <= '0;
      pend_q <= '0;
      done_q <= '0;
    end else begin
      ph_q   <= ph_d;
      act_q  <= act_d;
      pend_q <= pend_d;
      done_q <= done_d;
    end
  end

  // Data registers, clock-enabled, no reset
  always_ff @(posedge clk) begin
    if (accept) begin
      addr_q <= req_addr;
      we_q   <= req_we;
      wd_q   <= req_wdata;
    end
    for (int l = 0; l < LANES; l++) begin
      if (srv[l]) begin
        rd_q[l] <= b_rd[lbank[l]];
      end
    end
  end

  assign stall      = (ph_q == PH_RUN);
  assign lane_done  = done_q;
  assign lane_rdata = rd_q;

  // R3: an accepted request with work raises stall on the next cycle
  a_r3_stall_after_accept: assert property (@(posedge clk) disable iff (!rst_i)
    (req_valid && !stall && (|req_act)) |=> stall);

  // R6: every round retires at least one waiting lane
  a_r6_round_progress: assert property (@(posedge clk) disable iff (!rst_i)
    (ph_q == PH_RUN) |=> ($countones(pend_q) < $past($countones(pend_q))));

  // R4: when stall falls, exactly the active lanes are done
  a_r4_all_done_at_end: assert property (@(posedge clk) disable iff (!rst_i)
    $fell(stall) |-> (lane_done == act_q));

  // R8: done bits never fall while a request runs
  a_r8_done_hold: assert property (@(posedge clk) disable iff (!rst_i)
    (ph_q == PH_RUN) |=> ((lane_done & $past(lane_done)) == $past(lane_done)));

  // R8: an inactive lane is never marked done
  a_r8_no_stray_done: assert property (@(posedge clk) disable iff (!rst_i)
    ((lane_done & ~act_q) == '0));

endmodule

// File: tb/banked_scratchpad_tb.sv
`timescale 1ns/1ps
module banked_scratchpad_tb;

  localparam int LANES  = 32;
  localparam int BANKS  = 32;
  localparam int DEPTH  = 8;
  localparam int WORD_W = 32;
  localparam int ADDR_W = 8;
  localparam int NWORDS = BANKS * DEPTH;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic                         rst_n;
  logic                         req_valid;
  logic [LANES-1:0]             req_act;
  logic [LANES-1:0][ADDR_W-1:0] req_addr;
  logic [LANES-1:0]             req_we;
  logic [LANES-1:0][WORD_W-1:0] req_wdata;
  logic                         stall;
  logic [LANES-1:0]             lane_done;
  logic [LANES-1:0][WORD_W-1:0] lane_rdata;

  banked_scratchpad u_dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_act    (req_act),
    .req_addr   (req_addr),
    .req_we     (req_we),
    .req_wdata  (req_wdata),
    .stall      (stall),
    .lane_done  (lane_done),
    .lane_rdata (lane_rdata)
  );

  typedef struct {
    string            tag;
    int               rounds;
    logic [LANES-1:0] cum [0:LANES];
    logic [LANES-1:0] rdm;
    logic [WORD_W-1:0] rd [LANES];
  } exp_t;

  exp_t q[$];
  logic [WORD_W-1:0] shadow [NWORDS];
  int n_cmp = 0;
  int n_bad = 0;
  logic [LANES-1:0] last_done;
  exp_t last_e;

  task automatic chk(string tag, string what, logic [63:0] act, logic [63:0] expv);
    n_cmp++;
    if (act !== expv) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, expv);
    end
  endtask

  // Reference: rounds per bank in lowest-lane order, reads before writes,
  // highest writer wins.
  task automatic model(input logic [LANES-1:0] act, input logic [LANES-1:0] we,
                       input logic [LANES-1:0][ADDR_W-1:0] ad,
                       input logic [LANES-1:0][WORD_W-1:0] wd, inout exp_t e);
    logic [LANES-1:0] pend;
    int r;
    pend = act;
    r = 0;
    e.cum[0] = '0;
    e.rdm = act & ~we;
    while (pend != '0) begin
      logic [LANES-1:0] srv;
      logic [BANKS-1:0] taken;
      logic [ADDR_W-1:0] sel [BANKS];
      srv = '0;
      taken = '0;
      for (int l = 0; l < LANES; l++) begin
        if (pend[l] && !taken[ad[l] % BANKS]) begin
          taken[ad[l] % BANKS] = 1'b1;
          sel[ad[l] % BANKS] = ad[l];
        end
      end
      for (int l = 0; l < LANES; l++)
        if (pend[l] && sel[ad[l] % BANKS] == ad[l]) srv[l] = 1'b1;
      for (int l = 0; l < LANES; l++)
        if (srv[l] && !we[l]) e.rd[l] = shadow[ad[l]];
      for (int l = 0; l < LANES; l++)
        if (srv[l] && we[l]) shadow[ad[l]] = wd[l];
      pend = pend & ~srv;
      r++;
      e.cum[r] = e.cum[r-1] | srv;
    end
    e.rounds = r;
  endtask

  // Driver: called at a falling edge; pushes the expectation, drives, waits.
  task automatic send(string tag, input logic [LANES-1:0] act, input logic [LANES-1:0] we,
                      input logic [LANES-1:0][ADDR_W-1:0] ad,
                      input logic [LANES-1:0][WORD_W-1:0] wd, input bit intrude);
    exp_t e;
    e.tag = tag;
    model(act, we, ad, wd, e);
    q.push_back(e);
    req_valid = 1'b1;
    req_act   = act;
    req_we    = we;
    req_addr  = ad;
    req_wdata = wd;
    @(posedge clk);
    @(negedge clk);
    if (intrude) begin
      req_act = '1;
      req_we  = '1;
      for (int l = 0; l < LANES; l++) begin
        req_addr[l]  = 8'd5;
        req_wdata[l] = 32'hDEAD_0000 | l;
      end
      while (stall) @(negedge clk);
    end
    req_valid = 1'b0;
    wait (q.size() == 0);
    @(negedge clk);
  endtask

  // Monitor: compares the done vector every cycle and data at the end.
  initial begin
    forever begin : mon_loop
      exp_t e;
      int k;
      wait (q.size() > 0);
      e = q[0];
      @(posedge clk);
      k = 0;
      forever begin
        @(negedge clk);
        k++;
        chk(e.tag, "R8 done progress", lane_done,
            e.cum[(k - 1 > e.rounds) ? e.rounds : k - 1]);
        if (!stall || k > LANES + 2) break;
      end
      chk(e.tag, "stall cycles", k - 1, e.rounds);
      for (int l = 0; l < LANES; l++)
        if (e.rdm[l]) chk(e.tag, "rdata", lane_rdata[l], e.rd[l]);
      last_done = lane_done;
      last_e = e;
      void'(q.pop_front());
    end
  end

  initial begin
    #(20 * 150000);
    n_bad++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [LANES-1:0] act, we;
    logic [LANES-1:0][ADDR_W-1:0] ad;
    logic [LANES-1:0][WORD_W-1:0] wd;

    rst_n = 1'b0;
    req_valid = 1'b0;
    req_act = '0;
    req_we = '0;
    req_addr = '0;
    req_wdata = '0;
    repeat (3) @(negedge clk);
    chk("R1", "stall in reset", stall, 0);
    chk("R1", "done in reset", lane_done, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1", "stall after reset", stall, 0);
    chk("R1", "done after reset", lane_done, 0);

    // R4 R2: fill every word, one bank per lane, one cycle each
    for (int r = 0; r < DEPTH; r++) begin
      for (int l = 0; l < LANES; l++) begin
        ad[l] = ADDR_W'(r * BANKS + l);
        wd[l] = {16'hC0DE, 8'(r), 8'(l)};
      end
      send("R4", '1, '1, ad, wd, 1'b0);
    end

    // R2 R4: permuted banks, varied rows, reads only
    for (int l = 0; l < LANES; l++) begin
      ad[l] = ADDR_W'(((l * 7) % BANKS) + BANKS * (l % DEPTH));
      wd[l] = '0;
    end
    send("R2", '1, '0, ad, wd, 1'b0);

    // R5: every lane reads one word
    for (int l = 0; l < LANES; l++) ad[l] = 8'd37;
    send("R5", '1, '0, ad, wd, 1'b0);

    // R6: two words in bank 3, lanes 0..15 on the first
    for (int l = 0; l < LANES; l++) ad[l] = (l < 16) ? 8'd3 : 8'd35;
    send("R6", '1, '0, ad, wd, 1'b0);

    // R6: eight rows of bank 4, lowest lane on the highest row
    act = 32'h0000_00FF;
    for (int l = 0; l < LANES; l++) ad[l] = ADDR_W'(BANKS * (7 - (l % 8)) + 4);
    send("R6", act, '0, ad, wd, 1'b0);

    // R8: results held while idle
    repeat (3) @(negedge clk);
    chk("R8", "done held", lane_done, last_done);
    chk("R8", "rdata held", lane_rdata[0], last_e.rd[0]);

    // R7 R9: three writers and one reader on word 10
    act = '0;
    we = '0;
    for (int l = 0; l < LANES; l++) begin
      ad[l] = 8'd10;
      wd[l] = 32'h7700_0000 | l;
    end
    act[2] = 1'b1; we[2] = 1'b1;
    act[9] = 1'b1; we[9] = 1'b1;
    act[20] = 1'b1; we[20] = 1'b1;
    act[5] = 1'b1;
    send("R7 R9", act, we, ad, wd, 1'b0);
    act = 32'h1;
    send("R7", act, '0, ad, wd, 1'b0);

    // R10: empty request
    send("R10", '0, '0, ad, wd, 1'b0);

    // R3: four rounds in bank 0 while a second request tries to write word 5
    act = 32'hF;
    for (int l = 0; l < LANES; l++) ad[l] = ADDR_W'(BANKS * (l % 4));
    send("R3", act, '0, ad, wd, 1'b1);
    for (int l = 0; l < LANES; l++) ad[l] = 8'd5;
    send("R3", 32'h1, '0, ad, wd, 1'b0);

    // Mixed traffic with heavy conflicts
    for (int n = 0; n < 40; n++) begin
      act = $urandom;
      we  = $urandom & $urandom;
      for (int l = 0; l < LANES; l++) begin
        ad[l] = {3'($urandom), 5'($urandom_range(0, 3))};
        wd[l] = $urandom;
      end
      send("R6 R7 R9", act, we, ad, wd, 1'b0);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule